// File: doc/BRIEF.md
# High-Speed Transmit Slew-Rate Calibrator

This block calibrates the 3-bit transmit slew-rate code of one high-speed USB 2.0 PHY lane with no software involved. A one-cycle `start` pulse launches a fixed sequence. The block powers the lane's ring oscillator and waits for it to settle. It then opens the free-running clock gate and programs a frequency meter to count 1024 reference cycles. It enables the meter and polls the meter's valid flag at a fixed interval. Once the flag is seen, or the poll budget runs out, it reads the measured count, stops the meter and closes the clock gate.

The measured count is converted into a code. A serial divider computes 745472 ÷ count, which is 1024 × 26 × 28. The quotient is then scaled by 1/1000 with round-to-nearest. A zero count falls back to code 4, and codes above 7 are clamped to 7. The code is merged into the PHY control word, and the oscillator is switched off again. Every register touch is a read followed by a write through a simple request/acknowledge master port, so bits the block does not own are left as they were.

Top module: `hs_slew_cal`

## Requirements
- R1: Writes reach these addresses in this order: control (0x00), monitor (0x10), config (0x20) three times, monitor, control twice. The block makes no other writes. A request holds address, direction and write data steady until `m_ack`.
- R2: After the oscillator-enable write, no further access starts until at least CLK_MHZ cycles (1 µs) have passed.
- R3: The first config write puts 1024 in bits [23:0]. It keeps every bit outside [23:0] and [27:26].
- R4: With MAP_VARIANT 1, config bits [27:26] are lane_idx shifted right by one. With MAP_VARIANT 2 they are zero.
- R5: Monitor bit 0 is the valid flag. Successive polls are at least 10 µs apart. A lane whose flag never rises gets exactly 21 polls. The count register (0x24) is read after the last poll either way.
- R6: For a nonzero count C, the code is round-to-nearest((745472 div C) / 1000).
- R7: A zero count gives code 4.
- R8: A computed code above 7 is written as 7.
- R9: The control word has bit 15 as the oscillator enable and bits [14:12] as the slew code. Monitor bit 8 is the clock gate, and config bit 24 is the meter enable. Each write changes only the field named for that step. The code write replaces [14:12] completely.
- R10: `busy` rises the cycle after `start` and stays high until the final write is acknowledged. `done` then pulses exactly once with `busy` low. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration |
| lane_idx | input | LANE_W | Lane number, used for the monitor channel |
| m_req | output | 1 | Master request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | 8 | Register address |
| m_wdata | output | 32 | Write data |
| m_ack | input | 1 | One-cycle acknowledge from the register slave |
| m_rdata | input | 32 | Read data, valid with `m_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| slew_code | output | 3 | Last computed slew code |

## Verification
The assertions assume a well-behaved slave. It acknowledges each request exactly once, and it never raises `m_ack` without a pending request. They also assume the meter count stays stable while the divider runs. The bench's slave model acknowledges one cycle after it sees a request and drops the acknowledge for a cycle between operations. It returns the injected count unchanged for the whole run. It also raises the valid flag only while the meter-enable bit is set. Random control, monitor and config contents, with the owned bits cleared, show that untouched bits survive.

// File: rtl/slewcal_pkg.sv
package slewcal_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] A_CTRL = 8'h00;
    localparam logic [BUS_AW-1:0] A_MON  = 8'h10;
    localparam logic [BUS_AW-1:0] A_CFG  = 8'h20;
    localparam logic [BUS_AW-1:0] A_CNT  = 8'h24;

    localparam int CODE_W        = 3;
    localparam int CTRL_OSC_BIT  = 15;
    localparam int CTRL_SLEW_LSB = 12;
    localparam int MON_VALID_BIT = 0;
    localparam int MON_FRCK_BIT  = 8;
    localparam int CFG_CNT_W     = 24;
    localparam int CFG_EN_BIT    = 24;
    localparam int CFG_SEL_LSB   = 26;
    localparam int SEL_W         = 2;

    localparam int METER_CYCLES  = 1024;
    localparam int REF_MHZ       = 26;
    localparam int SR_COEF       = 28;
    localparam int SR_DIV        = 1000;
    localparam int CODE_DEFAULT  = 4;
    localparam int NUMERATOR     = METER_CYCLES * REF_MHZ * SR_COEF;

    localparam int SETTLE_US     = 1;
    localparam int POLL_US       = 10;
    localparam int POLL_LIMIT_US = 200;

    typedef enum logic [3:0] {
        S_IDLE, S_OSC_ON, S_SETTLE, S_FRCK_ON, S_CFG, S_MTR_ON, S_POLL,
        S_POLL_WAIT, S_CNT, S_MTR_OFF, S_FRCK_OFF, S_DIVIDE, S_CODE_WR, S_OSC_OFF
    } step_e;

    function automatic logic step_is_bus(step_e s);
        return !(s inside {S_IDLE, S_SETTLE, S_POLL_WAIT, S_DIVIDE});
    endfunction

    function automatic logic [BUS_AW-1:0] step_addr(step_e s);
        case (s)
            S_FRCK_ON, S_POLL, S_FRCK_OFF: return A_MON;
            S_CFG, S_MTR_ON, S_MTR_OFF:    return A_CFG;
            S_CNT:                         return A_CNT;
            default:                       return A_CTRL;
        endcase
    endfunction

    function automatic logic [BUS_DW-1:0] step_merge(step_e s, logic [BUS_DW-1:0] v,
                                                     logic [CODE_W-1:0] code, logic [SEL_W-1:0] sel);
        logic [BUS_DW-1:0] r;
        r = v;
        case (s)
            S_OSC_ON:   r[CTRL_OSC_BIT] = 1'b1;
            S_FRCK_ON:  r[MON_FRCK_BIT] = 1'b1;
            S_CFG: begin
                r[CFG_CNT_W-1:0]         = CFG_CNT_W'(METER_CYCLES);
                r[CFG_SEL_LSB +: SEL_W]  = sel;
            end
            S_MTR_ON:   r[CFG_EN_BIT] = 1'b1;
            S_MTR_OFF:  r[CFG_EN_BIT] = 1'b0;
            S_FRCK_OFF: r[MON_FRCK_BIT] = 1'b0;
            S_CODE_WR:  r[CTRL_SLEW_LSB +: CODE_W] = code;
            S_OSC_OFF:  r[CTRL_OSC_BIT] = 1'b0;
            default: ;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/slewcal_timer.sv
module slewcal_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == limit - 1'b1);

    assert_tmr_range_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !expired) |=> (!run || cnt < limit));
endmodule

// File: rtl/slewcal_divider.sv
module slewcal_divider #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             done,
    output logic [NUM_W-1:0] quotient
);
    localparam int IT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [IT_W-1:0]  iter;
    logic             active;
    logic [DEN_W:0]   trial;

    assign trial = {rem, quotient[NUM_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0; iter <= '0; active <= 1'b0; done <= 1'b0; quotient <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem <= '0; iter <= '0; active <= 1'b1; quotient <= dividend;
            end else if (active) begin
                if (trial >= {1'b0, divisor}) begin
                    rem      <= DEN_W'(trial - {1'b0, divisor});
                    quotient <= {quotient[NUM_W-2:0], 1'b1};
                end else begin
                    rem      <= trial[DEN_W-1:0];
                    quotient <= {quotient[NUM_W-2:0], 1'b0};
                end
                iter <= iter + 1'b1;
                if (iter == IT_W'(NUM_W - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assert_div_exact_R6: assert property (@(posedge clk) disable iff (rst)
        (done && divisor != '0) |->
        (64'(quotient) * 64'(divisor) <= 64'(dividend)) &&
        (64'(dividend) - 64'(quotient) * 64'(divisor) < 64'(divisor)));

    assert_div_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/slewcal_code.sv
module slewcal_code import slewcal_pkg::*; #(
    parameter int Q_W = 20
) (
    input  logic [Q_W-1:0]    quotient,
    input  logic              zero_cnt,
    output logic [CODE_W-1:0] code
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    logic [31:0]         biased;
    logic [CODE_MAX-1:0] over;

    assign biased = 32'(quotient) + 32'(SR_DIV / 2);

    for (genvar k = 0; k < CODE_MAX; k++) begin : g_step
        assign over[k] = biased >= 32'((k + 1) * SR_DIV);
    end

    assign code = zero_cnt ? CODE_W'(CODE_DEFAULT) : CODE_W'($countones(over));
endmodule

// File: rtl/hs_slew_cal.sv
module hs_slew_cal import slewcal_pkg::*; #(
    parameter int CLK_MHZ     = 200,
    parameter int MAP_VARIANT = 1,
    parameter int LANE_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LANE_W-1:0] lane_idx,
    output logic              m_req,
    output logic              m_we,
    output logic [BUS_AW-1:0] m_addr,
    output logic [BUS_DW-1:0] m_wdata,
    input  logic              m_ack,
    input  logic [BUS_DW-1:0] m_rdata,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] slew_code
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int POLL_CYC   = CLK_MHZ * POLL_US;
    localparam int POLL_MAX   = POLL_LIMIT_US / POLL_US;
    localparam int TMR_W      = $clog2(POLL_CYC + 1);
    localparam int PC_W       = $clog2(POLL_MAX + 1);
    localparam int NUM_W      = $clog2(NUMERATOR + 1);

    step_e              step;
    logic               wr_ph;
    logic [BUS_DW-1:0]  hold;
    logic [BUS_DW-1:0]  meas;
    logic [PC_W-1:0]    polls;
    logic [SEL_W-1:0]   sel_q;
    logic [SEL_W-1:0]   sel_c;
    logic [CODE_W-1:0]  code_q;
    logic [CODE_W-1:0]  code_c;
    logic               div_go;
    logic               div_done;
    logic [NUM_W-1:0]   quo;
    logic               tmr_run;
    logic               tmr_exp;
    logic [TMR_W-1:0]   tmr_lim;

    if (MAP_VARIANT == 1) begin : g_sel_lane
        assign sel_c = SEL_W'(lane_idx >> 1);
    end else begin : g_sel_zero
        assign sel_c = '0;
    end

    assign tmr_run = (step == S_SETTLE) || (step == S_POLL_WAIT);
    assign tmr_lim = (step == S_SETTLE) ? TMR_W'(SETTLE_CYC) : TMR_W'(POLL_CYC);

    slewcal_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .run(tmr_run), .limit(tmr_lim), .expired(tmr_exp)
    );

    slewcal_divider #(.NUM_W(NUM_W), .DEN_W(BUS_DW)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .dividend(NUM_W'(NUMERATOR)),
        .divisor(meas), .done(div_done), .quotient(quo)
    );

    slewcal_code #(.Q_W(NUM_W)) u_code (
        .quotient(quo), .zero_cnt(meas == '0), .code(code_c)
    );

    assign m_req     = step_is_bus(step);
    assign m_we      = wr_ph;
    assign m_addr    = step_addr(step);
    assign m_wdata   = step_merge(step, hold, code_q, sel_q);
    assign busy      = (step != S_IDLE);
    assign slew_code = code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= S_IDLE; wr_ph <= 1'b0; hold <= '0; meas <= '0; polls <= '0;
            sel_q <= '0; code_q <= '0; div_go <= 1'b0; done <= 1'b0;
        end else begin
            div_go <= 1'b0;
            done   <= 1'b0;
            case (step)
                S_IDLE: if (start) begin
                    step <= S_OSC_ON; wr_ph <= 1'b0; sel_q <= sel_c;
                end
                S_SETTLE: if (tmr_exp) step <= S_FRCK_ON;
                S_POLL_WAIT: if (tmr_exp) begin
                    polls <= polls + 1'b1; step <= S_POLL;
                end
                S_DIVIDE: if (div_done) begin
                    code_q <= code_c; step <= S_CODE_WR;
                end
                default: if (m_ack) begin
                    if (!wr_ph) begin
                        hold <= m_rdata;
                        if (step == S_POLL) begin
                            if (m_rdata[MON_VALID_BIT] || polls == PC_W'(POLL_MAX)) step <= S_CNT;
                            else step <= S_POLL_WAIT;
                        end else if (step == S_CNT) begin
                            meas <= m_rdata; step <= S_MTR_OFF;
                        end else begin
                            wr_ph <= 1'b1;
                        end
                    end else begin
                        wr_ph <= 1'b0;
                        case (step)
                            S_OSC_ON:   step <= S_SETTLE;
                            S_FRCK_ON:  step <= S_CFG;
                            S_CFG:      step <= S_MTR_ON;
                            S_MTR_ON:   begin step <= S_POLL; polls <= '0; end
                            S_MTR_OFF:  step <= S_FRCK_OFF;
                            S_FRCK_OFF: begin step <= S_DIVIDE; div_go <= 1'b1; end
                            S_CODE_WR:  step <= S_OSC_OFF;
                            default:    begin step <= S_IDLE; done <= 1'b1; end
                        endcase
                    end
                end
            endcase
        end
    end

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

    assert_poll_bound_R5: assert property (@(posedge clk) disable iff (rst)
        polls <= PC_W'(POLL_MAX));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

// File: tb/tb_hs_slew_cal.sv
module tb_hs_slew_cal;
    import slewcal_pkg::*;

    localparam int MHZ = 20;
    localparam int US1 = MHZ;
    localparam int US10 = MHZ * 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] lane_i = 3'd0;
    logic req, we, ack = 1'b0, busy, done;
    logic [7:0] addr;
    logic [31:0] wdata, rdata = '0;
    logic [2:0] code;

    logic req2, we2, ack2 = 1'b0, busy2, done2;
    logic [7:0] addr2;
    logic [31:0] wdata2;
    logic [2:0] code2;
    logic cfg2_seen = 1'b0;
    logic [31:0] cfg2_w = '0;

    always #2.5 clk = ~clk;

    hs_slew_cal #(.CLK_MHZ(MHZ), .MAP_VARIANT(1), .LANE_W(3)) dut (
        .clk(clk), .rst(rst), .start(start), .lane_idx(lane_i),
        .m_req(req), .m_we(we), .m_addr(addr), .m_wdata(wdata),
        .m_ack(ack), .m_rdata(rdata), .busy(busy), .done(done), .slew_code(code));

    hs_slew_cal #(.CLK_MHZ(MHZ), .MAP_VARIANT(2), .LANE_W(3)) dut2 (
        .clk(clk), .rst(rst), .start(start), .lane_idx(3'd7),
        .m_req(req2), .m_we(we2), .m_addr(addr2), .m_wdata(wdata2),
        .m_ack(ack2), .m_rdata(32'd0), .busy(busy2), .done(done2), .slew_code(code2));

    int nchk = 0, nfail = 0;
    int cyc = 0, done_n = 0;
    logic ld = 1'b0;
    logic [31:0] ld_ctrl, ld_mon, ld_cfg, inj_cnt = '0;
    int valid_after = 0;
    logic [31:0] r_ctrl = '0, r_mon = '0, r_cfg = '0;
    logic [7:0] wr_a [16];
    logic [31:0] wr_d [16];
    int wr_n = 0, poll_n = 0, t_osc = 0, t_poll = 0, settle = 0, gmin = 0, gmax = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) done_n <= done_n + 1;
        if (ld) begin
            r_ctrl <= ld_ctrl; r_mon <= ld_mon; r_cfg <= ld_cfg;
            wr_n <= 0; poll_n <= 0; gmin <= 999999; gmax <= 0; settle <= 0;
        end
        if (ack) ack <= 1'b0;
        else if (req) begin
            ack <= 1'b1;
            if (we) begin
                case (addr)
                    A_CTRL: r_ctrl <= wdata;
                    A_MON:  r_mon  <= wdata;
                    A_CFG:  r_cfg  <= wdata;
                    default: ;
                endcase
                if (wr_n < 16) begin wr_a[wr_n] <= addr; wr_d[wr_n] <= wdata; end
                wr_n <= wr_n + 1;
                if (wr_n == 0) t_osc <= cyc;
            end else begin
                case (addr)
                    A_CTRL: rdata <= r_ctrl;
                    A_CFG:  rdata <= r_cfg;
                    A_CNT:  rdata <= inj_cnt;
                    A_MON: begin
                        rdata <= r_mon | {31'd0, (r_cfg[CFG_EN_BIT] && poll_n >= valid_after)};
                        if (r_cfg[CFG_EN_BIT]) begin
                            poll_n <= poll_n + 1;
                            t_poll <= cyc;
                            if (poll_n > 0) begin
                                if (cyc - t_poll < gmin) gmin <= cyc - t_poll;
                                if (cyc - t_poll > gmax) gmax <= cyc - t_poll;
                            end
                        end
                        if (wr_n == 1) settle <= cyc - t_osc;
                    end
                    default: rdata <= '0;
                endcase
            end
        end
    end

    always @(posedge clk) begin
        if (ack2) ack2 <= 1'b0;
        else if (req2) begin
            ack2 <= 1'b1;
            if (we2 && addr2 == A_CFG && !cfg2_seen) begin
                cfg2_seen <= 1'b1; cfg2_w <= wdata2;
            end
        end
    end

    function automatic int exp_code(input int unsigned c);
        int unsigned q, r;
        if (c == 0) return 4;
        q = 745472 / c;
        r = (q + 500) / 1000;
        if (r > 7) r = 7;
        return int'(r);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic run_case(input int unsigned cnt, input int va, input logic [2:0] lane, input bit again);
        logic [31:0] ci, mi, fi;
        logic [31:0] w [8];
        logic [7:0] ea [8];
        string tag [8];
        int ec, n0, t, ep;
        string ctag;
        ci = $urandom & ~(32'h1 << CTRL_OSC_BIT);
        mi = $urandom & ~32'h0000_0101;
        fi = $urandom & ~(32'h1 << CFG_EN_BIT);
        @(negedge clk);
        ld_ctrl = ci; ld_mon = mi; ld_cfg = fi; inj_cnt = cnt; valid_after = va; lane_i = lane; ld = 1'b1;
        @(negedge clk);
        ld = 1'b0; n0 = done_n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
        if (again) begin
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_n == n0 && t < 20000) begin @(negedge clk); t++; end
        chk(t < 20000, "R10 watchdog", 32'(t), 32'd20000);
        repeat (3) @(negedge clk);
        chk(done_n == n0 + 1, "R10 single done pulse", 32'(done_n - n0), 32'd1);
        chk(busy == 1'b0, "R10 idle after done", 32'(busy), 32'd0);

        ec = exp_code(cnt);
        w[0] = ci | (32'h1 << CTRL_OSC_BIT);
        w[1] = mi | (32'h1 << MON_FRCK_BIT);
        w[2] = (fi & ~32'h0CFF_FFFF) | 32'd1024 | (32'(lane >> 1) << CFG_SEL_LSB);
        w[3] = w[2] | (32'h1 << CFG_EN_BIT);
        w[4] = w[2];
        w[5] = mi;
        w[6] = (w[0] & ~(32'h7 << CTRL_SLEW_LSB)) | (32'(ec) << CTRL_SLEW_LSB);
        w[7] = w[6] & ~(32'h1 << CTRL_OSC_BIT);
        ea = '{A_CTRL, A_MON, A_CFG, A_CFG, A_CFG, A_MON, A_CTRL, A_CTRL};
        tag = '{"R1 osc on", "R9 gate on", "R3 R4 config", "R9 meter on", "R9 meter off",
                "R9 gate off", "R9 code write", "R1 osc off"};
        chk(wr_n == 8, "R1 write count", 32'(wr_n), 32'd8);
        for (int i = 0; i < 8; i++) begin
            chk(wr_a[i] == ea[i] && wr_d[i] == w[i], tag[i], wr_d[i], w[i]);
        end
        ctag = (cnt == 0) ? "R7 zero count code" : (ec == 7) ? "R8 saturated code" : "R6 code";
        chk(code == 3'(ec), ctag, 32'(code), 32'(ec));
        chk(r_ctrl == w[7], "R9 final control word", r_ctrl, w[7]);
        ep = ((va > 20) ? 20 : va) + 1;
        chk(poll_n == ep, "R5 poll reads", 32'(poll_n), 32'(ep));
        if (ep >= 2)
            chk(gmin >= US10 && gmax <= US10 + 6, "R5 poll spacing", 32'(gmin), 32'(US10));
        chk(settle >= US1 && settle <= US1 + 6, "R2 settle gap", 32'(settle), 32'(US1));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && req == 1'b0 && done == 1'b0, "R10 reset state",
            {29'd0, busy, req, done}, 32'd0);
        rst = 1'b0;
        run_case(0, 0, 3'd5, 1'b0);
        run_case(1, 1, 3'd2, 1'b0);
        run_case(93, 2, 3'd6, 1'b0);
        run_case(497, 0, 3'd3, 1'b1);
        run_case(496, 3, 3'd1, 1'b0);
        run_case(700, 999, 3'd7, 1'b0);
        run_case(186, 1, 3'd4, 1'b0);
        for (int k = 0; k < 10; k++) begin
            run_case($urandom_range(1, 3000), int'($urandom_range(0, 4)), 3'($urandom_range(0, 7)), 1'b0);
        end
        begin
            int t2;
            t2 = 0;
            while (busy2 && t2 < 20000) begin @(negedge clk); t2++; end
            chk(cfg2_seen && cfg2_w == 32'd1024, "R4 variant two select zero", cfg2_w, 32'd1024);
            chk(code2 == 3'd4, "R7 timeout with zero count", 32'(code2), 32'd4);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule